// File: doc/BRIEF.md
# Seconds-Counter Real-Time Clock with Alarm

This block is a memory-mapped real-time clock for a slow 32.768 kHz domain. A prescaler divides the input clock by a programmable divider. An optional trim count lengthens one period in every group of periods, which corrects crystal drift. Each prescaler tick advances a 32-bit seconds counter. When the counter's new value matches a 32-bit alarm register, an alarm event is recorded.

Two sticky event flags, one for ticks and one for alarm matches, sit in a status register beside their interrupt enables. Each flag drives its own interrupt line through its enable. Software reads and writes the four registers through a simple single-cycle port. A parameter picks one of two address layouts. After reset the divider/trim register is zero, which holds the prescaler still. Software is expected to load the divider (32767 for a 1 Hz tick from 32.768 kHz) and set the counter.

Top module: `sec_rtc`

## Requirements
- R1: With LAYOUT=0 the alarm register is at offset 0x00, the counter at 0x04, divider/trim at 0x08 and status at 0x10. Any other address reads 0, and a write to it changes nothing.
- R2: With LAYOUT=1 the counter is at 0x0, the alarm at 0x4, status at 0x8 and divider/trim at 0xC. Any other address reads 0.
- R3: After reset the counter, alarm, divider/trim and status registers all read 0, and both interrupt outputs are low.
- R4: With divider D>0 and trim 0, the counter increments by one every D+1 clock cycles. With divider 0 the prescaler is held and the counter does not move.
- R5: With trim T, each group of TRIM_EVERY periods counted from a restart ends in one period of D+1+T cycles. All other periods stay D+1 cycles.
- R6: A write to the counter loads the written value and restarts the prescaler phase and group count. The next increment comes D+1 cycles after the write edge.
- R7: Status bit 1 (second flag) is set on every tick, and bit 0 (alarm flag) is set on a tick whose incremented count equals the alarm register. Both are set regardless of the enables. A counter write that equals the alarm does not set bit 0.
- R8: Writing 1 to status bit 0 or 1 clears that flag, and writing 0 leaves it alone. Bits 2 (alarm enable) and 3 (second enable) take the written value. Status bits 31:4 read 0.
- R9: When a flag is set and a write-one-to-clear of that flag fall on the same cycle, the flag stays set.
- R10: irq_second is high exactly when status bits 1 and 3 are both 1. irq_alarm is high exactly when status bits 0 and 2 are both 1.
- R11: The divider/trim register holds the divider in bits 15:0 and the trim in bits 25:16, and bits 31:26 read 0. The counter and alarm hold full 32-bit values, and the counter wraps from 0xFFFFFFFF to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz timebase clock, also used by the register port |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| irq_second | output | 1 | Tick interrupt: second flag AND second enable |
| irq_alarm | output | 1 | Alarm interrupt: alarm flag AND alarm enable |

## Verification
The assertions assume that the bus write strobe is a clean single-cycle pulse. They also assume that the written divider is nonzero whenever tick spacing is being relied on, since a zero divider holds the prescaler. The bench drives every write and read half a cycle away from the active edge, one access per cycle. It keeps a global edge count, so each expected counter value and flag state is computed from the write edge plus the divider and trim arithmetic. The bench uses a group size of four periods, which makes trimmed periods appear within a few dozen cycles. Its sweeps over small divider and trim values stay short enough that neither the counter nor the group count wraps by accident.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ALARM,
        SEL_COUNT,
        SEL_DIVTRIM,
        SEL_STATUS
    } reg_sel_e;

    // status register bit positions (software decodes these)
    localparam int ST_AL_FLAG = 0;
    localparam int ST_HZ_FLAG = 1;
    localparam int ST_AL_EN   = 2;
    localparam int ST_HZ_EN   = 3;
    localparam int ST_BITS    = 4;

endpackage

// File: rtl/sec_rtc_decode.sv
module sec_rtc_decode
    import sec_rtc_pkg::*;
#(
    parameter int LAYOUT = 0,
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_e          sel_o
);

    logic [ADDR_W-1:0] off_alarm;
    logic [ADDR_W-1:0] off_count;
    logic [ADDR_W-1:0] off_divtrim;
    logic [ADDR_W-1:0] off_status;

    generate
        if (LAYOUT == 0) begin : g_map_a
            assign off_alarm   = ADDR_W'(8'h00);
            assign off_count   = ADDR_W'(8'h04);
            assign off_divtrim = ADDR_W'(8'h08);
            assign off_status  = ADDR_W'(8'h10);
        end else begin : g_map_b
            assign off_count   = ADDR_W'(8'h00);
            assign off_alarm   = ADDR_W'(8'h04);
            assign off_status  = ADDR_W'(8'h08);
            assign off_divtrim = ADDR_W'(8'h0C);
        end
    endgenerate

    always_comb begin
        sel_o = SEL_NONE;
        if (addr_i == off_alarm) begin
            sel_o = SEL_ALARM;
        end else if (addr_i == off_count) begin
            sel_o = SEL_COUNT;
        end else if (addr_i == off_divtrim) begin
            sel_o = SEL_DIVTRIM;
        end else if (addr_i == off_status) begin
            sel_o = SEL_STATUS;
        end
    end

endmodule

// File: rtl/sec_rtc_prescaler.sv
module sec_rtc_prescaler #(
    parameter int DIV_W      = 16,
    parameter int TRIM_W     = 10,
    parameter int TRIM_EVERY = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [TRIM_W-1:0] trim_i,
    input  logic              restart_i,
    output logic              tick_o
);

    localparam int PH_W  = DIV_W + 1;
    localparam int GRP_W = (TRIM_EVERY > 2) ? $clog2(TRIM_EVERY) : 1;

    typedef struct packed {
        logic [PH_W-1:0]  phase;
        logic [GRP_W-1:0] grp;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic [PH_W-1:0] limit;
    logic            running;
    logic            long_period;
    logic            tick;

    always_comb begin
        running     = (div_i != '0);
        long_period = (st_q.grp == GRP_W'(TRIM_EVERY - 1));
        limit       = {1'b0, div_i} + (long_period ? PH_W'(trim_i) : '0);
        tick        = 1'b0;
        st_d        = st_q;
        if (restart_i || !running) begin
            st_d.phase = '0;
            st_d.grp   = '0;
        end else if (st_q.phase >= limit) begin
            tick       = 1'b1;
            st_d.phase = '0;
            st_d.grp   = long_period ? '0 : st_q.grp + 1'b1;
        end else begin
            st_d.phase = st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = tick;

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);                                            // R4
    AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> !tick_o);                                         // R6
    AST_HELD_WHEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (div_i == '0) && $past(div_i == '0) |-> !tick_o);               // R4

endmodule

// File: rtl/sec_rtc_timebase.sv
module sec_rtc_timebase #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             wr_cnt_i,
    input  logic             wr_alarm_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] alarm_o,
    output logic             hit_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] alarm;
    } tb_state_t;

    tb_state_t        st_d, st_q;
    logic [CNT_W-1:0] next_cnt;
    logic             hit;

    always_comb begin
        st_d     = st_q;
        next_cnt = st_q.cnt + 1'b1;
        hit      = 1'b0;
        if (wr_cnt_i) begin
            st_d.cnt = wdata_i;
        end else if (tick_i) begin
            st_d.cnt = next_cnt;
            hit      = (next_cnt == st_q.alarm);
        end
        if (wr_alarm_i) begin
            st_d.alarm = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o   = st_q.cnt;
    assign alarm_o = st_q.alarm;
    assign hit_o   = hit;

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i && !wr_cnt_i |=> cnt_o == $past(cnt_o) + 1'b1);          // R4
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i && !wr_cnt_i |=> $stable(cnt_o));                       // R4
    AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt_i |=> cnt_o == $past(wdata_i));                          // R6
    AST_HIT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> tick_i && !wr_cnt_i);                                 // R7

endmodule

// File: rtl/sec_rtc_status.sv
module sec_rtc_status
    import sec_rtc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [ST_BITS-1:0] wdata_i,
    input  logic               set_hz_i,
    input  logic               set_al_i,
    output logic [ST_BITS-1:0] stat_o,
    output logic               irq_hz_o,
    output logic               irq_al_o
);

    typedef struct packed {
        logic hz_en;
        logic al_en;
        logic hz_flag;
        logic al_flag;
    } st_state_t;

    st_state_t st_d, st_q;
    logic      clr_hz, clr_al;
    logic      hz_flag, al_flag;

    always_comb begin
        st_d   = st_q;
        clr_hz = wr_i && wdata_i[ST_HZ_FLAG];
        clr_al = wr_i && wdata_i[ST_AL_FLAG];
        if (wr_i) begin
            st_d.hz_en = wdata_i[ST_HZ_EN];
            st_d.al_en = wdata_i[ST_AL_EN];
        end
        st_d.hz_flag = (st_q.hz_flag && !clr_hz) || set_hz_i;
        st_d.al_flag = (st_q.al_flag && !clr_al) || set_al_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hz_flag  = st_q.hz_flag;
    assign al_flag  = st_q.al_flag;
    assign stat_o   = st_q;
    assign irq_hz_o = st_q.hz_flag && st_q.hz_en;
    assign irq_al_o = st_q.al_flag && st_q.al_en;

    AST_SET_WINS_HZ: assert property (@(posedge clk) disable iff (!rst_n)
        set_hz_i |=> hz_flag);                                          // R9
    AST_SET_WINS_AL: assert property (@(posedge clk) disable iff (!rst_n)
        set_al_i |=> al_flag);                                          // R9
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        hz_flag && !(wr_i && wdata_i[ST_HZ_FLAG]) |=> hz_flag);         // R8
    AST_ALARM_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(al_flag) |-> $past(set_al_i));                            // R7

endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
    import sec_rtc_pkg::*;
#(
    parameter int LAYOUT     = 0,
    parameter int ADDR_W     = 5,
    parameter int DATA_W     = 32,
    parameter int DIV_W      = 16,
    parameter int TRIM_W     = 10,
    parameter int TRIM_EVERY = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_second,
    output logic              irq_alarm
);

    localparam int DT_W  = DIV_W + TRIM_W;
    localparam int PAD_W = DATA_W - DT_W;

    typedef struct packed {
        logic [TRIM_W-1:0] trim;
        logic [DIV_W-1:0]  div;
    } divtrim_t;

    reg_sel_e           sel;
    divtrim_t           dt_d, dt_q;
    logic               wr_alarm, wr_cnt, wr_dt, wr_stat;
    logic               tick, hit;
    logic [DATA_W-1:0]  cnt, alarm;
    logic [ST_BITS-1:0] stat;

    sec_rtc_decode #(
        .LAYOUT (LAYOUT),
        .ADDR_W (ADDR_W)
    ) u_decode (
        .addr_i (bus_addr),
        .sel_o  (sel)
    );

    always_comb begin
        wr_alarm = bus_wr && (sel == SEL_ALARM);
        wr_cnt   = bus_wr && (sel == SEL_COUNT);
        wr_dt    = bus_wr && (sel == SEL_DIVTRIM);
        wr_stat  = bus_wr && (sel == SEL_STATUS);
        dt_d     = dt_q;
        if (wr_dt) begin
            dt_d = bus_wdata[DT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dt_q <= '0;
        end else begin
            dt_q <= dt_d;
        end
    end

    sec_rtc_prescaler #(
        .DIV_W      (DIV_W),
        .TRIM_W     (TRIM_W),
        .TRIM_EVERY (TRIM_EVERY)
    ) u_prescaler (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_i     (dt_q.div),
        .trim_i    (dt_q.trim),
        .restart_i (wr_cnt),
        .tick_o    (tick)
    );

    sec_rtc_timebase #(
        .CNT_W (DATA_W)
    ) u_timebase (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .wr_cnt_i   (wr_cnt),
        .wr_alarm_i (wr_alarm),
        .wdata_i    (bus_wdata),
        .cnt_o      (cnt),
        .alarm_o    (alarm),
        .hit_o      (hit)
    );

    sec_rtc_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (wr_stat),
        .wdata_i  (bus_wdata[ST_BITS-1:0]),
        .set_hz_i (tick),
        .set_al_i (hit),
        .stat_o   (stat),
        .irq_hz_o (irq_second),
        .irq_al_o (irq_alarm)
    );

    always_comb begin
        case (sel)
            SEL_ALARM:   bus_rdata = alarm;
            SEL_COUNT:   bus_rdata = cnt;
            SEL_DIVTRIM: bus_rdata = {{PAD_W{1'b0}}, dt_q};
            SEL_STATUS:  bus_rdata = {{(DATA_W-ST_BITS){1'b0}}, stat};
            default:     bus_rdata = '0;
        endcase
    end

    AST_DIVTRIM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && sel == SEL_DIVTRIM) |=> $stable(dt_q));             // R11
    AST_IRQ_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_second) |-> $past(tick) || $past(wr_stat));           // R10

endmodule

// File: tb/sec_rtc_test.sv
`timescale 1ns/1ps
module sec_rtc_test;

    localparam int GRP = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata_a, rdata_b;
    logic        irqs_a, irqa_a, irqs_b, irqa_b;
    int          n_vec = 0;
    int          n_bad = 0;
    int          edge_n = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) edge_n <= edge_n + 1;

    sec_rtc #(.LAYOUT(0), .TRIM_EVERY(GRP)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr),
        .bus_wdata(wdata), .bus_rdata(rdata_a),
        .irq_second(irqs_a), .irq_alarm(irqa_a));

    sec_rtc #(.LAYOUT(1), .TRIM_EVERY(GRP)) uut_b (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr),
        .bus_wdata(wdata), .bus_rdata(rdata_b),
        .irq_second(irqs_b), .irq_alarm(irqa_b));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    // one edge consumed; samples both instances before the edge
    task automatic rd(input logic [4:0] a, output logic [31:0] da, output logic [31:0] db);
        addr = a;
        #1;
        da = rdata_a;
        db = rdata_b;
        @(negedge clk);
    endtask

    task automatic wait_to(input int e);
        while (edge_n < e) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin : main
        logic [31:0] va, vb;
        int w, w2, len;
        logic [31:0] base;

        do_reset();
        // R3: reset state
        for (int a = 0; a <= 5'h14; a += 4) begin
            rd(5'(a), va, vb);
            chk("R3 reset read A", va, 32'h0);
            chk("R3 reset read B", vb, 32'h0);
        end
        chk("R3 irq lines", {28'h0, irqs_a, irqa_a, irqs_b, irqa_b}, 32'h0);

        // R1/R2 map, R11 field widths
        wr_reg(5'h00, 32'hA5A5_0001);
        wr_reg(5'h04, 32'h5A5A_0002);
        wr_reg(5'h08, 32'hFFFF_FFFF);
        wr_reg(5'h0C, 32'h1234_5678);
        wr_reg(5'h10, 32'h0000_000C);
        wr_reg(5'h14, 32'hFFFF_FFFF);
        rd(5'h00, va, vb); chk("R1 alarm@00", va, 32'hA5A5_0001); chk("R2 count@0", vb, 32'hA5A5_0001);
        rd(5'h04, va, vb); chk("R1 count@04", va, 32'h5A5A_0002); chk("R2 alarm@4", vb, 32'h5A5A_0002);
        rd(5'h08, va, vb); chk("R11 divtrim@08", va, 32'h03FF_FFFF); chk("R2 status@8", vb, 32'h0000_000C);
        rd(5'h0C, va, vb); chk("R1 unmapped 0C", va, 32'h0); chk("R2 divtrim@C", vb, 32'h0234_5678);
        rd(5'h10, va, vb); chk("R1 status@10", va, 32'h0000_000C); chk("R2 unmapped 10", vb, 32'h0);
        rd(5'h14, va, vb); chk("R1 unmapped 14", va, 32'h0); chk("R2 unmapped 14", vb, 32'h0);

        do_reset();
        rd(5'h04, va, vb); chk("R3 count after reset", va, 32'h0);
        rd(5'h08, va, vb); chk("R3 divtrim after reset", va, 32'h0);

        // R4/R5/R6 sweep over divider and trim
        for (int d = 1; d <= 4; d++) begin
            for (int t = 0; t <= 3; t += (t == 0) ? 1 : 2) begin
                base = 32'(100 * d + t);
                wr_reg(5'h08, 32'((t << 16) | d));
                wr_reg(5'h04, base);
                w   = edge_n;
                len = GRP * (d + 1) + t;
                wait_to(w + d);       rd(5'h04, va, vb); chk("R6 no tick before D+1", va, base);
                wait_to(w + d + 1);   rd(5'h04, va, vb); chk("R4 first tick at D+1", va, base + 1);
                wait_to(w + len - 1); rd(5'h04, va, vb); chk("R5 long period pending", va, base + 3);
                wait_to(w + len);     rd(5'h04, va, vb); chk("R5 long period end", va, base + 4);
                wait_to(w + 2 * len); rd(5'h04, va, vb); chk("R5 second group", va, base + 8);
            end
        end

        // R4: divider zero holds the counter
        wr_reg(5'h08, 32'h0);
        wr_reg(5'h04, 32'd7);
        w = edge_n;
        wait_to(w + 20); rd(5'h04, va, vb); chk("R4 divider zero holds", va, 32'd7);

        // R11 wrap, R7 alarm at zero
        wr_reg(5'h00, 32'h0);
        wr_reg(5'h08, 32'd1);
        wr_reg(5'h10, 32'h3);
        wr_reg(5'h04, 32'hFFFF_FFFF);
        w = edge_n;
        wait_to(w + 2); rd(5'h04, va, vb); chk("R11 counter wrap", va, 32'h0);
        rd(5'h10, va, vb); chk("R7 alarm on wrap", va, 32'h3);

        // flag / interrupt sequence
        do_reset();
        wr_reg(5'h08, 32'd9);
        wr_reg(5'h00, 32'd12);
        wr_reg(5'h04, 32'd10);
        w = edge_n;
        wait_to(w + 10); rd(5'h10, va, vb); chk("R7 second flag without enable", va, 32'h2);
        chk("R10 no irq while disabled", {30'h0, irqs_a, irqa_a}, 32'h0);
        rd(5'h04, va, vb); chk("R4 count 11", va, 32'd11);
        wait_to(w + 12); wr_reg(5'h10, 32'h2);
        rd(5'h10, va, vb); chk("R8 write-one clears", va, 32'h0);
        wait_to(w + 20); rd(5'h10, va, vb); chk("R7 alarm match", va, 32'h3);
        wr_reg(5'h10, 32'hC);
        chk("R10 both irqs", {30'h0, irqs_a, irqa_a}, 32'h3);
        rd(5'h10, va, vb); chk("R8 zero keeps flags", va, 32'hF);
        wr_reg(5'h10, 32'hD);
        chk("R10 alarm irq dropped", {30'h0, irqs_a, irqa_a}, 32'h2);
        rd(5'h10, va, vb); chk("R8 clear alarm only", va, 32'hE);
        wr_reg(5'h10, 32'hFFFF_FFFA);
        chk("R10 irqs low", {30'h0, irqs_a, irqa_a}, 32'h0);
        rd(5'h10, va, vb); chk("R8 upper bits read 0", va, 32'h8);
        wait_to(w + 30);
        chk("R10 second irq", {30'h0, irqs_a, irqa_a}, 32'h2);
        rd(5'h10, va, vb); chk("R7 no alarm past match", va, 32'hA);

        // R9: clear on the tick edge
        wait_to(w + 39); wr_reg(5'h10, 32'hA);
        rd(5'h10, va, vb); chk("R9 set beats clear", va, 32'hA);

        // R6: mid-period counter write restarts phase; R7 write-equal no alarm
        wait_to(w + 44); wr_reg(5'h04, 32'd12);
        w2 = edge_n;
        wait_to(w2 + 5); rd(5'h04, va, vb); chk("R6 old tick suppressed", va, 32'd12);
        rd(5'h10, va, vb); chk("R7 write equal no alarm", va, 32'hA);
        wait_to(w2 + 10); rd(5'h04, va, vb); chk("R6 tick after restart", va, 32'd13);
        rd(5'h10, va, vb); chk("R7 no alarm at 13", va, 32'hA);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'h0, 32'h1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule